// File: doc/BRIEF.md
# Reseeding Logic Self-Test Sequencer

This block drives an on-chip logic self-test without an external tester. A processor or host writes a small configuration bank while the sequencer is idle: a table of pattern-generator seeds, how many of them to use, the shift length, the number of patterns per seed, an expected signature and a watchdog cycle limit. A start command then makes the sequencer run through the seeds in table order. Each seed is loaded into a 16-bit pattern-generator LFSR, and a programmed number of patterns follows. Each pattern is a shift phase with scan-enable high and then one capture cycle with scan-enable low. While shifting, the low LFSR bits feed the scan-chain inputs and the scan-chain outputs are folded into a 16-bit MISR.

Once the last pattern of the last seed has been applied, the sequencer spends one cycle comparing the MISR with the expected signature. It then raises a done flag together with a pass or a fail flag, and gives a one-cycle functional reset pulse so the logic under test returns to a known state. If the programmed watchdog limit runs out first, the run is aborted with done and timeout set. The result flags hold until the next start.

Top module: `lbist_seq`

## Requirements
- R1: Configuration writes (`cfg_we_i`) take effect only while `busy_o` is low. The register map is: address 0 is the shift length, 1 the patterns per seed, 2 the seed count, 3 the expected signature, 4 the watchdog limit, and 8+k is seed table entry k. Writes made while `busy_o` is high change nothing.
- R2: `start_i` seen high while idle begins a run. In the next cycle `busy_o` is high, all result flags are 0, `signature_o` is 0 and the LFSR holds seed entry 0. `start_i` during a run is ignored.
- R3: Each pattern holds `scan_en_o` high for exactly shift-length consecutive cycles, followed by exactly one cycle with `capture_o` high and `scan_en_o` low. Both are low while idle.
- R4: Seed count S, P patterns and shift length N give S·P capture cycles and S·P·N shift cycles. The run lasts exactly S·P·(N+1)+1 cycles with `busy_o` high, the last of which is the compare cycle.
- R5: `scan_in_o` is the low CHAINS bits of the LFSR. In every shift cycle the LFSR advances as next = {q[14:0], q[15]^q[13]^q[12]^q[10]}. At the start of seed k it is reloaded from table entry k, in ascending k.
- R6: In each shift cycle the MISR becomes {m[14:0], m[15]^m[13]^m[12]^m[10]} XOR the zero-extended `scan_out_i`. In all other cycles it holds, except that a start clears it. `signature_o` shows it.
- R7: At the end of a completed run, `done_o` is 1 and `pass_o` is 1 exactly when the MISR equals the expected signature. Otherwise `fail_o` is 1. At most one of pass, fail and timeout is ever set.
- R8: A nonzero watchdog limit L aborts a run that has not reached its compare cycle by busy cycle L. `busy_o` then falls after exactly L busy cycles with `done_o` and `timeout_o` set and pass and fail clear. A limit of 0 disables the watchdog.
- R9: `func_rst_o` is high for exactly one cycle, in the first cycle in which `done_o` is high, after both completion and abort.
- R10: Reset clears every flag and output. The done, pass, fail and timeout flags stay unchanged from the end of a run until the next accepted start.
- R11: A seed count, pattern count or shift length of 0 makes the run go straight to its compare cycle. It lasts 1 busy cycle with no shift or capture, and the cleared signature is compared.
- R12: A seed count written above MAX_SEEDS is stored as MAX_SEEDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Configuration register address |
| cfg_wdata_i | input | 16 | Configuration write data |
| start_i | input | 1 | Start command |
| scan_out_i | input | CHAINS | Scan-chain outputs to be compacted |
| scan_in_o | output | CHAINS | Scan-chain stimulus from the LFSR |
| scan_en_o | output | 1 | Scan enable, high while shifting |
| capture_o | output | 1 | Capture strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished or aborted |
| pass_o | output | 1 | Signature matched |
| fail_o | output | 1 | Signature mismatched |
| timeout_o | output | 1 | Watchdog abort |
| func_rst_o | output | 1 | One-cycle reset pulse for the logic under test |
| signature_o | output | 16 | Current MISR contents |

## Verification
- Start: `busy_o` rises and `signature_o` reads zero one edge after the cycle in which `start_i` is taken. Shift and capture strobes follow from that cycle onward.
- Completion: the flags appear one edge after the compare cycle, so `busy_o` falls after exactly S·P·(N+1)+1 high cycles. `func_rst_o` is high only in that first done cycle.
- Abort: the watchdog brings `busy_o` down after exactly L busy cycles.
- How the bench samples: it drives and samples on falling edges and counts busy, shift and capture cycles per run. It checks the flags and the signature at the first falling edge with `busy_o` low, and the pulse end and the held flags at the following edges. The expected signature comes from a cycle model of the loopback chains and both polynomials.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam int SIG_W = 16;
  // taps 16,14,13,11 (primitive)
  localparam logic [SIG_W-1:0] POLY_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_CAPT,
    ST_CHECK
  } seq_st_e;

  function automatic logic [SIG_W-1:0] poly_step(input logic [SIG_W-1:0] v);
    return {v[SIG_W-2:0], ^(v & POLY_TAPS)};
  endfunction
endpackage

// File: rtl/lbist_cfg.sv
module lbist_cfg #(
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 8,
  parameter int WDOG_W    = 16,
  parameter int MAX_SEEDS = 4,
  localparam int SCNT_W   = $clog2(MAX_SEEDS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic                         lock_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [15:0]                  wdata_i,
  output logic [CNT_W-1:0]             shift_len_o,
  output logic [CNT_W-1:0]             pat_len_o,
  output logic [SCNT_W-1:0]            seed_cnt_o,
  output logic [15:0]                  golden_o,
  output logic [WDOG_W-1:0]            wdog_lim_o,
  output logic [MAX_SEEDS-1:0][15:0]   seed_tbl_o
);
  localparam int SEED_BASE = 8;
  localparam logic [ADDR_W-1:0] A_SHIFT  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PAT    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SEEDS  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_GOLDEN = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_WDOG   = ADDR_W'(4);

  logic wr;
  assign wr = we_i && !lock_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_len_o <= '0;
      pat_len_o   <= '0;
      seed_cnt_o  <= '0;
      golden_o    <= '0;
      wdog_lim_o  <= '0;
    end else if (wr) begin
      case (addr_i)
        A_SHIFT:  shift_len_o <= wdata_i[CNT_W-1:0];
        A_PAT:    pat_len_o   <= wdata_i[CNT_W-1:0];
        A_SEEDS:  seed_cnt_o  <= (wdata_i > 16'(MAX_SEEDS)) ? SCNT_W'(MAX_SEEDS)
                                                             : wdata_i[SCNT_W-1:0];
        A_GOLDEN: golden_o    <= wdata_i;
        A_WDOG:   wdog_lim_o  <= wdata_i[WDOG_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < MAX_SEEDS; g++) begin : g_seed
    localparam logic [ADDR_W-1:0] A_ENT = ADDR_W'(SEED_BASE + g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 seed_tbl_o[g] <= '0;
      else if (wr && addr_i == A_ENT) seed_tbl_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/lbist_lfsr.sv
module lbist_lfsr
  import lbist_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SIG_W-1:0] seed_i,
  input  logic             adv_i,
  output logic [SIG_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= seed_i;
    else if (adv_i)  q_o <= poly_step(q_o);
  end
endmodule

// File: rtl/lbist_misr.sv
module lbist_misr
  import lbist_pkg::*;
#(
  parameter int CHAINS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [CHAINS-1:0] data_i,
  output logic [SIG_W-1:0]  sig_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sig_o <= '0;
    else if (clr_i) sig_o <= '0;
    else if (en_i)  sig_o <= poly_step(sig_o) ^ SIG_W'(data_i);
  end
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
  import lbist_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int WDOG_W    = 16,
  parameter int MAX_SEEDS = 4,
  localparam int SIDX_W   = $clog2(MAX_SEEDS),
  localparam int SCNT_W   = $clog2(MAX_SEEDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  shift_len_i,
  input  logic [CNT_W-1:0]  pat_len_i,
  input  logic [SCNT_W-1:0] seed_cnt_i,
  input  logic [WDOG_W-1:0] wdog_lim_i,
  input  logic              match_i,
  output logic              busy_o,
  output logic              scan_en_o,
  output logic              capture_o,
  output logic              lfsr_load_o,
  output logic [SIDX_W-1:0] load_idx_o,
  output logic              misr_clr_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic              func_rst_o
);
  seq_st_e           st_q;
  logic [CNT_W-1:0]  shift_q, pat_q;
  logic [SIDX_W-1:0] seed_q;
  logic [WDOG_W-1:0] wdog_q;

  logic start_acc, shift_last, pat_last, seed_last, any_zero, wd_hit;

  always_comb begin
    busy_o     = (st_q != ST_IDLE);
    start_acc  = start_i && !busy_o;
    shift_last = (shift_q == shift_len_i - 1'b1);
    pat_last   = (pat_q == pat_len_i - 1'b1);
    seed_last  = (SCNT_W'(seed_q) == seed_cnt_i - 1'b1);
    any_zero   = (shift_len_i == '0) || (pat_len_i == '0) || (seed_cnt_i == '0);
    wd_hit     = busy_o && (st_q != ST_CHECK) && (wdog_lim_i != '0)
                 && (wdog_q == wdog_lim_i - 1'b1);
    scan_en_o  = (st_q == ST_SHIFT);
    capture_o  = (st_q == ST_CAPT);
    misr_clr_o = start_acc;
    lfsr_load_o = start_acc ||
                  ((st_q == ST_CAPT) && pat_last && !seed_last && !wd_hit);
    load_idx_o = start_acc ? '0 : seed_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      shift_q    <= '0;
      pat_q      <= '0;
      seed_q     <= '0;
      wdog_q     <= '0;
      done_o     <= 1'b0;
      pass_o     <= 1'b0;
      fail_o     <= 1'b0;
      timeout_o  <= 1'b0;
      func_rst_o <= 1'b0;
    end else begin
      func_rst_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (start_acc) begin
          st_q      <= any_zero ? ST_CHECK : ST_SHIFT;
          shift_q   <= '0;
          pat_q     <= '0;
          seed_q    <= '0;
          wdog_q    <= '0;
          done_o    <= 1'b0;
          pass_o    <= 1'b0;
          fail_o    <= 1'b0;
          timeout_o <= 1'b0;
        end
      end else if (wd_hit) begin
        st_q       <= ST_IDLE;
        done_o     <= 1'b1;
        timeout_o  <= 1'b1;
        func_rst_o <= 1'b1;
      end else begin
        wdog_q <= wdog_q + 1'b1;
        case (st_q)
          ST_SHIFT: begin
            if (shift_last) begin
              shift_q <= '0;
              st_q    <= ST_CAPT;
            end else begin
              shift_q <= shift_q + 1'b1;
            end
          end
          ST_CAPT: begin
            if (pat_last) begin
              pat_q <= '0;
              if (seed_last) begin
                st_q <= ST_CHECK;
              end else begin
                seed_q <= seed_q + 1'b1;
                st_q   <= ST_SHIFT;
              end
            end else begin
              pat_q <= pat_q + 1'b1;
              st_q  <= ST_SHIFT;
            end
          end
          ST_CHECK: begin
            st_q       <= ST_IDLE;
            done_o     <= 1'b1;
            pass_o     <= match_i;
            fail_o     <= !match_i;
            func_rst_o <= 1'b1;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lbist_seq.sv
module lbist_seq
  import lbist_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CHAINS    = 4,
  parameter int CNT_W     = 8,
  parameter int WDOG_W    = 16,
  parameter int MAX_SEEDS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic              start_i,
  input  logic [CHAINS-1:0] scan_out_i,
  output logic [CHAINS-1:0] scan_in_o,
  output logic              scan_en_o,
  output logic              capture_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic              func_rst_o,
  output logic [15:0]       signature_o
);
  localparam int SIDX_W = $clog2(MAX_SEEDS);
  localparam int SCNT_W = $clog2(MAX_SEEDS + 1);

  logic [CNT_W-1:0]           shift_len_w, pat_len_w;
  logic [SCNT_W-1:0]          seed_cnt_w;
  logic [15:0]                golden_w;
  logic [WDOG_W-1:0]          wdog_lim_w;
  logic [MAX_SEEDS-1:0][15:0] seed_tbl_w;
  logic                       lfsr_load_w, misr_clr_w;
  logic [SIDX_W-1:0]          load_idx_w;
  logic [SIG_W-1:0]           lfsr_w;

  lbist_cfg #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .WDOG_W(WDOG_W), .MAX_SEEDS(MAX_SEEDS)
  ) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .lock_i     (busy_o),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .shift_len_o(shift_len_w),
    .pat_len_o  (pat_len_w),
    .seed_cnt_o (seed_cnt_w),
    .golden_o   (golden_w),
    .wdog_lim_o (wdog_lim_w),
    .seed_tbl_o (seed_tbl_w)
  );

  lbist_ctrl #(
    .CNT_W(CNT_W), .WDOG_W(WDOG_W), .MAX_SEEDS(MAX_SEEDS)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .shift_len_i(shift_len_w),
    .pat_len_i  (pat_len_w),
    .seed_cnt_i (seed_cnt_w),
    .wdog_lim_i (wdog_lim_w),
    .match_i    (signature_o == golden_w),
    .busy_o     (busy_o),
    .scan_en_o  (scan_en_o),
    .capture_o  (capture_o),
    .lfsr_load_o(lfsr_load_w),
    .load_idx_o (load_idx_w),
    .misr_clr_o (misr_clr_w),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .timeout_o  (timeout_o),
    .func_rst_o (func_rst_o)
  );

  lbist_lfsr u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(lfsr_load_w),
    .seed_i(seed_tbl_w[load_idx_w]),
    .adv_i (scan_en_o),
    .q_o   (lfsr_w)
  );

  lbist_misr #(.CHAINS(CHAINS)) u_misr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (misr_clr_w),
    .en_i  (scan_en_o),
    .data_i(scan_out_i),
    .sig_o (signature_o)
  );

  assign scan_in_o = lfsr_w[CHAINS-1:0];
endmodule

// File: rtl/lbist_seq_chk.sv
module lbist_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        scan_en_o,
  input logic        capture_o,
  input logic        done_o,
  input logic        pass_o,
  input logic        fail_o,
  input logic        timeout_o,
  input logic        func_rst_o,
  input logic [15:0] signature_o,
  input logic [15:0] golden_w
);
  assert_cfg_lock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(golden_w));

  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scan_en_o && capture_o));

  assert_capture_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> !capture_o);

  assert_capture_after_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |-> $past(scan_en_o));

  assert_idle_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(scan_en_o || capture_o));

  assert_misr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_en_o && !(start_i && !busy_o)) |=> $stable(signature_o));

  assert_verdict_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pass_o, fail_o, timeout_o}));

  assert_verdict_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o || fail_o || timeout_o) |-> done_o);

  assert_rst_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_rst_o |=> !func_rst_o);

  assert_rst_on_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> func_rst_o);

  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind lbist_seq lbist_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .scan_en_o  (scan_en_o),
  .capture_o  (capture_o),
  .done_o     (done_o),
  .pass_o     (pass_o),
  .fail_o     (fail_o),
  .timeout_o  (timeout_o),
  .func_rst_o (func_rst_o),
  .signature_o(signature_o),
  .golden_w   (golden_w)
);

// File: tb/sim_lbist_seq.sv
`timescale 1ns/1ps
module sim_lbist_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        start_i = 1'b0;
  logic [3:0]  scan_out_i;
  logic [3:0]  scan_in_o;
  logic        scan_en_o, capture_o, busy_o, done_o, pass_o, fail_o, timeout_o, func_rst_o;
  logic [15:0] signature_o;

  always #2.5 clk = ~clk;

  lbist_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .start_i(start_i), .scan_out_i(scan_out_i),
    .scan_in_o(scan_in_o), .scan_en_o(scan_en_o), .capture_o(capture_o),
    .busy_o(busy_o), .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o),
    .timeout_o(timeout_o), .func_rst_o(func_rst_o), .signature_o(signature_o)
  );

  // loopback chains: 4 chains, 3 stages; capture inverts, functional reset clears
  logic [3:0] ch0, ch1, ch2;
  assign scan_out_i = ch2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || func_rst_o) begin
      ch0 <= '0; ch1 <= '0; ch2 <= '0;
    end else if (scan_en_o) begin
      ch0 <= scan_in_o; ch1 <= ch0; ch2 <= ch1;
    end else if (capture_o) begin
      ch0 <= ~ch0; ch1 <= ~ch1; ch2 <= ~ch2;
    end
  end

  int n_chk = 0, n_fail = 0;
  int n_se, n_cap, bad_run, cur_run, exp_sh;
  logic [15:0] seeds [4];

  always @(negedge clk) begin
    if (scan_en_o) cur_run++;
    if (scan_en_o) n_se++;
    if (capture_o) begin
      n_cap++;
      if (cur_run != exp_sh || scan_en_o) bad_run++;
      cur_run = 0;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got hung expected finish");
    summary();
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stp(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  function automatic logic [15:0] ref_sig(input int sh, input int pt, input int sd);
    logic [15:0] m, l;
    logic [3:0] c0, c1, c2;
    m = '0; c0 = '0; c1 = '0; c2 = '0;
    for (int s = 0; s < sd; s++) begin
      l = seeds[s];
      for (int p = 0; p < pt; p++) begin
        for (int n = 0; n < sh; n++) begin
          m = stp(m) ^ {12'b0, c2};
          c2 = c1; c1 = c0; c0 = l[3:0];
          l = stp(l);
        end
        c0 = ~c0; c1 = ~c1; c2 = ~c2;
      end
    end
    return m;
  endfunction

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_addr_i = 4'(a); cfg_wdata_i = d;
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  task automatic setup(input int sh, input int pt, input int sd, input logic [15:0] g);
    wr(0, 16'(sh)); wr(1, 16'(pt)); wr(2, 16'(sd)); wr(3, g);
    exp_sh = sh;
  endtask

  // inject: writes and a start while busy
  task automatic run(input bit inject, output int cyc);
    @(negedge clk);
    n_se = 0; n_cap = 0; bad_run = 0; cur_run = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "busy after start", busy_o, 1);
    chk("R2", "signature cleared", signature_o, 0);
    chk("R10", "done cleared by start", done_o, 0);
    cyc = 0;
    while (busy_o && cyc < 1000) begin
      cyc++;
      if (inject && cyc == 3) begin
        cfg_we_i = 1'b1; cfg_addr_i = 4'd3; cfg_wdata_i = 16'hDEAD;
      end else if (inject && cyc == 4) begin
        cfg_we_i = 1'b1; cfg_addr_i = 4'd0; cfg_wdata_i = 16'd1;
      end else if (inject && cyc == 5) begin
        cfg_we_i = 1'b0; start_i = 1'b1;
      end else begin
        cfg_we_i = 1'b0; start_i = 1'b0;
      end
      @(negedge clk);
    end
    cfg_we_i = 1'b0; start_i = 1'b0;
  endtask

  task automatic post_checks(input bit exp_pass, input bit exp_to);
    chk("R7", "done", done_o, 1);
    chk("R7", "pass", pass_o, exp_pass && !exp_to);
    chk("R7", "fail", fail_o, !exp_pass && !exp_to);
    chk("R8", "timeout", timeout_o, exp_to);
    chk("R9", "func reset pulse", func_rst_o, 1);
    @(negedge clk);
    chk("R9", "func reset ends", func_rst_o, 0);
    chk("R10", "done held", done_o, 1);
  endtask

  initial begin
    int cyc, idx;
    logic [15:0] e, g;
    seeds[0] = 16'hACE1; seeds[1] = 16'h1234; seeds[2] = 16'h0F0F; seeds[3] = 16'hBEEF;
    repeat (3) @(negedge clk);
    chk("R10", "reset flags", {busy_o, done_o, pass_o, fail_o, timeout_o, func_rst_o}, 0);
    chk("R3", "reset strobes", {scan_en_o, capture_o}, 0);
    chk("R6", "reset signature", signature_o, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) wr(8 + k, seeds[k]);

    // sweep of shift length, pattern count, seed count
    idx = 0;
    for (int sh = 1; sh <= 3; sh++)
      for (int pt = 1; pt <= 2; pt++)
        for (int sd = 1; sd <= 4; sd++) begin
          e = ref_sig(sh, pt, sd);
          g = (idx % 3 == 2) ? (e ^ 16'h0100) : e;
          setup(sh, pt, sd, g);
          run(1'b0, cyc);
          chk("R4", "busy cycles", cyc, sd * pt * (sh + 1) + 1);
          chk("R3", "shift cycles", n_se, sd * pt * sh);
          chk("R4", "capture cycles", n_cap, sd * pt);
          chk("R3", "shift run length", bad_run, 0);
          chk("R5 R6", "signature", signature_o, e);
          post_checks(idx % 3 != 2, 1'b0);
          idx++;
        end

    // sticky status
    repeat (8) @(negedge clk);
    chk("R10", "flags held idle", {done_o, pass_o, fail_o, timeout_o}, 4'b1010);

    // seed count saturation
    e = ref_sig(2, 1, 4);
    setup(2, 1, 9, e);
    run(1'b0, cyc);
    chk("R12", "saturated busy cycles", cyc, 4 * 1 * 3 + 1);
    chk("R12", "saturated signature", signature_o, e);
    post_checks(1'b1, 1'b0);

    // zero pattern count
    setup(2, 0, 2, 16'h0000);
    run(1'b0, cyc);
    chk("R11", "zero-count busy cycles", cyc, 1);
    chk("R11", "zero-count shifts", n_se + n_cap, 0);
    post_checks(1'b1, 1'b0);
    setup(0, 2, 2, 16'h0001);
    run(1'b0, cyc);
    chk("R11", "zero shift busy cycles", cyc, 1);
    post_checks(1'b0, 1'b0);

    // writes and start during a run are ignored
    e = ref_sig(3, 2, 2);
    setup(3, 2, 2, e);
    run(1'b1, cyc);
    chk("R1", "busy cycles with writes", cyc, 17);
    chk("R1", "shift length kept", n_se, 12);
    chk("R2", "restart ignored", n_cap, 4);
    post_checks(1'b1, 1'b0);
    run(1'b0, cyc);
    chk("R1", "rerun golden kept", pass_o, 1);
    post_checks(1'b1, 1'b0);

    // watchdog boundary
    wr(4, 16'd16);
    run(1'b0, cyc);
    chk("R8", "abort busy cycles", cyc, 16);
    post_checks(1'b0, 1'b1);
    wr(4, 16'd17);
    run(1'b0, cyc);
    chk("R8", "limit equal to run", cyc, 17);
    post_checks(1'b1, 1'b0);
    wr(4, 16'd0);
    run(1'b0, cyc);
    chk("R8", "disabled watchdog", cyc, 17);
    post_checks(1'b1, 1'b0);

    summary();
  end
endmodule